// File: doc/BRIEF.md
# Line Region Masking Sequencer

This block decides, for each sensor line presented during frame readout, whether the line is sent out or skipped. Software loads a small table of line windows, each given by a first and a last line address, and then writes how many of those windows are in use. The readout sequencer marks each frame with a start strobe and an end strobe. Between them it gives a line-start strobe together with the line index. One cycle later the block answers with a valid pulse and a mask bit. Because every skipped line saves a fixed slice of readout time, the block also counts the skipped lines. At the end of each frame it reports that total, so the frame length can be shortened to match.

Every window write is checked before it is accepted. The addresses must fall on a four-line grid, stay inside the sensor, and span at least four lines. A bad write, or a window count above the table size, raises an error pulse and changes nothing. Writing a legal count takes a snapshot of the staged windows. That snapshot only becomes the live table at the next frame start, so a frame is never judged against two different tables.

Top module: `line_mask_seq`

## Requirements
- R1: The table holds five windows and the count accepts 0 to 5. Only the first `count` windows take part in masking. A count write above 5 is rejected.
- R2: A window's first address must be a multiple of 4. Its last address must be a multiple of 4 or equal 3499, the last sensor line. Any other value is rejected.
- R3: A window is rejected if either address is above 3499, if its last address is below its first address plus 3, or if its index is 5 or more.
- R4: A rejected write drives `cfg_err` high for exactly the one cycle after the write and leaves the staged window unchanged. An accepted write leaves `cfg_err` low.
- R5: A legal count write snapshots the staged windows. The snapshot becomes live only at the next `frame_start`, so lines of the frame already in progress keep the old table.
- R6: With a live count of 0, no line is masked and the frame total is 0.
- R7: A line is masked when its index lies between the first and last address of any live window, with both ends included.
- R8: Overlapping windows are allowed. A line covered by several windows is counted once in the frame total.
- R9: The skipped-line counter clears at `frame_start`. At `frame_end`, `skip_total` takes the number of masked lines of that frame and holds it until the next `frame_end`.
- R10: Each `line_start` gives exactly one `line_vld` pulse in the following cycle, carrying that line's mask bit. `line_masked` is never high without `line_vld`.
- R11: After a synchronous reset, the live count is 0 and all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| win_we | input | 1 | Window write strobe |
| win_idx | input | 3 | Window slot to write |
| win_first | input | 12 | First line address of the window |
| win_last | input | 12 | Last line address of the window |
| cnt_we | input | 1 | Window-count write strobe; commits the staged list |
| cnt_val | input | 3 | Number of windows in use |
| frame_start | input | 1 | Frame boundary; the pending table becomes live here |
| frame_end | input | 1 | End of frame; latches the skipped-line total |
| line_start | input | 1 | A line is about to be read out |
| line_idx | input | 12 | Index of that line |
| line_vld | output | 1 | Decision for the previous line_start is valid |
| line_masked | output | 1 | 1 when that line is skipped |
| skip_total | output | 12 | Masked lines counted in the last finished frame |
| cfg_err | output | 1 | One-cycle pulse after a rejected write |

## Verification
Whole frames of all 3500 lines are run against several tables. The first has no live windows, which separates "mask nothing" from any stuck mask. Next come three disjoint windows, including one that ends on the unaligned last line, which tests the inclusive edges at both ends of the sensor. Two overlapping windows show whether the total counts a line twice. A full set of five windows, some only four lines long, exercises every slot and the narrowest span. A count written in the middle of a frame shows whether the table switches at the boundary or mid-frame. A run of illegal writes followed by a recommit shows whether a rejected write disturbed the staged entries.

// File: rtl/lrm_pkg.sv
package lrm_pkg;

    localparam int LINE_W     = 12;
    localparam int ALIGN_BITS = 2;

    typedef logic [LINE_W-1:0] line_t;

    typedef struct packed {
        line_t first;
        line_t last;
    } win_t;

    // Legality of one window against the last sensor line.
    function automatic logic win_legal(input line_t first, input line_t last, input line_t lim);
        logic first_ok;
        logic last_ok;
        logic span_ok;
        first_ok = (first[ALIGN_BITS-1:0] == '0) && (first <= lim);
        last_ok  = ((last[ALIGN_BITS-1:0] == '0) || (last == lim)) && (last <= lim);
        span_ok  = {1'b0, last} >= ({1'b0, first} + (LINE_W+1)'(3));
        return first_ok && last_ok && span_ok;
    endfunction

    // Inclusive coverage test of a line by a window.
    function automatic logic win_covers(input win_t w, input line_t idx);
        return (idx >= w.first) && (idx <= w.last);
    endfunction

endpackage

// File: rtl/lrm_table.sv
module lrm_table
    import lrm_pkg::*;
#(
    parameter int NUM_WIN   = 5,
    parameter int LAST_LINE = 3499,
    parameter int IDX_W     = $clog2(NUM_WIN),
    parameter int CNT_W     = $clog2(NUM_WIN + 1)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     win_we,
    input  logic [IDX_W-1:0]         win_idx,
    input  line_t                    win_first,
    input  line_t                    win_last,
    input  logic                     cnt_we,
    input  logic [CNT_W-1:0]         cnt_val,
    input  logic                     frame_start,
    output win_t [NUM_WIN-1:0]       act_tab,
    output logic [CNT_W-1:0]         act_cnt,
    output logic                     cfg_err
);

    localparam line_t LIM = line_t'(LAST_LINE);

    win_t [NUM_WIN-1:0] stage_tab;
    win_t [NUM_WIN-1:0] pend_tab;
    logic [CNT_W-1:0]   pend_cnt;
    logic               pend_v;

    logic win_good;
    logic cnt_good;

    always_comb begin
        win_good = ({1'b0, win_idx} < (IDX_W+1)'(NUM_WIN))
                   && win_legal(win_first, win_last, LIM);
        cnt_good = cnt_val <= CNT_W'(NUM_WIN);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_tab <= '0;
            pend_tab  <= '0;
            pend_cnt  <= '0;
            pend_v    <= 1'b0;
            act_tab   <= '0;
            act_cnt   <= '0;
            cfg_err   <= 1'b0;
        end else begin
            cfg_err <= (win_we && !win_good) || (cnt_we && !cnt_good);
            if (win_we && win_good) begin
                stage_tab[win_idx] <= '{first: win_first, last: win_last};
            end
            if (frame_start && pend_v) begin
                act_tab <= pend_tab;
                act_cnt <= pend_cnt;
                pend_v  <= 1'b0;
            end
            if (cnt_we && cnt_good) begin
                pend_tab <= stage_tab;
                pend_cnt <= cnt_val;
                pend_v   <= 1'b1;
            end
        end
    end

    // R5
    act_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !frame_start |=> $stable(act_cnt) && $stable(act_tab));

    // R1
    cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
        act_cnt <= CNT_W'(NUM_WIN));

    // R4
    err_cause_chk: assert property (@(posedge clk) disable iff (rst)
        cfg_err |-> $past(win_we || cnt_we));

    // R4
    err_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        (win_we && !win_good && !cnt_we) |=> cfg_err && $stable(stage_tab));

endmodule

// File: rtl/lrm_judge.sv
module lrm_judge
    import lrm_pkg::*;
#(
    parameter int NUM_WIN = 5,
    parameter int CNT_W   = $clog2(NUM_WIN + 1)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               line_start,
    input  line_t              line_idx,
    input  win_t [NUM_WIN-1:0] act_tab,
    input  logic [CNT_W-1:0]   act_cnt,
    output logic               hit,
    output logic               line_vld,
    output logic               line_masked
);

    logic [NUM_WIN-1:0] hit_w;

    generate
        for (genvar k = 0; k < NUM_WIN; k++) begin : g_win
            assign hit_w[k] = (CNT_W'(k) < act_cnt) && win_covers(act_tab[k], line_idx);
        end
    endgenerate

    assign hit = |hit_w;

    always_ff @(posedge clk) begin
        if (rst) begin
            line_vld    <= 1'b0;
            line_masked <= 1'b0;
        end else begin
            line_vld    <= line_start;
            line_masked <= line_start && hit;
        end
    end

    // R10
    mask_needs_vld_chk: assert property (@(posedge clk) disable iff (rst)
        line_masked |-> line_vld);

    // R10
    vld_follows_start_chk: assert property (@(posedge clk) disable iff (rst)
        line_start |=> line_vld);

    // R6
    zero_cnt_pass_chk: assert property (@(posedge clk) disable iff (rst)
        (line_start && act_cnt == '0) |=> !line_masked);

endmodule

// File: rtl/lrm_skip.sv
module lrm_skip
    import lrm_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  frame_start,
    input  logic  frame_end,
    input  logic  skip_inc,
    output line_t skip_total
);

    line_t run_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_cnt    <= '0;
            skip_total <= '0;
        end else begin
            if (frame_start) begin
                run_cnt <= '0;
            end else if (skip_inc) begin
                run_cnt <= run_cnt + line_t'(1);
            end
            if (frame_end) begin
                skip_total <= run_cnt;
            end
        end
    end

    // R9
    run_clear_chk: assert property (@(posedge clk) disable iff (rst)
        frame_start |=> run_cnt == '0);

    // R8
    run_step_chk: assert property (@(posedge clk) disable iff (rst)
        !frame_start |=> (run_cnt == $past(run_cnt)) || (run_cnt == $past(run_cnt) + line_t'(1)));

    // R9
    total_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !frame_end |=> $stable(skip_total));

endmodule

// File: rtl/line_mask_seq.sv
module line_mask_seq
    import lrm_pkg::*;
#(
    parameter int NUM_WIN   = 5,
    parameter int LAST_LINE = 3499,
    parameter int IDX_W     = $clog2(NUM_WIN),
    parameter int CNT_W     = $clog2(NUM_WIN + 1)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 win_we,
    input  logic [IDX_W-1:0]     win_idx,
    input  logic [LINE_W-1:0]    win_first,
    input  logic [LINE_W-1:0]    win_last,
    input  logic                 cnt_we,
    input  logic [CNT_W-1:0]     cnt_val,
    input  logic                 frame_start,
    input  logic                 frame_end,
    input  logic                 line_start,
    input  logic [LINE_W-1:0]    line_idx,
    output logic                 line_vld,
    output logic                 line_masked,
    output logic [LINE_W-1:0]    skip_total,
    output logic                 cfg_err
);

    win_t [NUM_WIN-1:0] act_tab;
    logic [CNT_W-1:0]   act_cnt;
    logic               hit;

    lrm_table #(
        .NUM_WIN   (NUM_WIN),
        .LAST_LINE (LAST_LINE),
        .IDX_W     (IDX_W),
        .CNT_W     (CNT_W)
    ) u_table (
        .clk         (clk),
        .rst         (rst),
        .win_we      (win_we),
        .win_idx     (win_idx),
        .win_first   (win_first),
        .win_last    (win_last),
        .cnt_we      (cnt_we),
        .cnt_val     (cnt_val),
        .frame_start (frame_start),
        .act_tab     (act_tab),
        .act_cnt     (act_cnt),
        .cfg_err     (cfg_err)
    );

    lrm_judge #(
        .NUM_WIN (NUM_WIN),
        .CNT_W   (CNT_W)
    ) u_judge (
        .clk         (clk),
        .rst         (rst),
        .line_start  (line_start),
        .line_idx    (line_idx),
        .act_tab     (act_tab),
        .act_cnt     (act_cnt),
        .hit         (hit),
        .line_vld    (line_vld),
        .line_masked (line_masked)
    );

    lrm_skip u_skip (
        .clk         (clk),
        .rst         (rst),
        .frame_start (frame_start),
        .frame_end   (frame_end),
        .skip_inc    (line_start && hit),
        .skip_total  (skip_total)
    );

    // R11
    reset_quiet_chk: assert property (@(posedge clk)
        rst |=> !line_vld && !line_masked && !cfg_err && skip_total == '0);

endmodule

// File: tb/line_mask_seq_test.sv
module line_mask_seq_test;
    import lrm_pkg::*;

    localparam int NW   = 5;
    localparam int LAST = 3499;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        win_we = 1'b0;
    logic [2:0]  win_idx = '0;
    logic [11:0] win_first = '0;
    logic [11:0] win_last = '0;
    logic        cnt_we = 1'b0;
    logic [2:0]  cnt_val = '0;
    logic        frame_start = 1'b0;
    logic        frame_end = 1'b0;
    logic        line_start = 1'b0;
    logic [11:0] line_idx = '0;
    logic        line_vld;
    logic        line_masked;
    logic [11:0] skip_total;
    logic        cfg_err;

    always #2.5 clk = ~clk;

    line_mask_seq uut (
        .clk (clk), .rst (rst),
        .win_we (win_we), .win_idx (win_idx), .win_first (win_first), .win_last (win_last),
        .cnt_we (cnt_we), .cnt_val (cnt_val),
        .frame_start (frame_start), .frame_end (frame_end),
        .line_start (line_start), .line_idx (line_idx),
        .line_vld (line_vld), .line_masked (line_masked),
        .skip_total (skip_total), .cfg_err (cfg_err)
    );

    int vectors = 0;
    int miscompares = 0;
    string cur_req = "R7";
    bit exp_q[$];
    int idx_q[$];
    int exp_skip = 0;

    int st_f[NW], st_l[NW], pe_f[NW], pe_l[NW], ac_f[NW], ac_l[NW];
    int pe_cnt = 0, ac_cnt = 0;
    bit pe_v = 0;

    task automatic chk(input string req, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic bit model_hit(input int i);
        for (int k = 0; k < ac_cnt; k++)
            if (i >= ac_f[k] && i <= ac_l[k]) return 1'b1;
        return 1'b0;
    endfunction

    task automatic write_win(input int k, input int f, input int l, input bit ok, input string req);
        win_we = 1'b1; win_idx = 3'(k); win_first = 12'(f); win_last = 12'(l);
        @(negedge clk);
        win_we = 1'b0;
        chk(req, int'(cfg_err), int'(!ok));
        if (ok && k < NW) begin st_f[k] = f; st_l[k] = l; end
    endtask

    task automatic write_cnt(input int n, input bit ok, input string req);
        cnt_we = 1'b1; cnt_val = 3'(n);
        @(negedge clk);
        cnt_we = 1'b0;
        chk(req, int'(cfg_err), int'(!ok));
        if (ok) begin
            for (int k = 0; k < NW; k++) begin pe_f[k] = st_f[k]; pe_l[k] = st_l[k]; end
            pe_cnt = n; pe_v = 1'b1;
        end
    endtask

    task automatic frame_begin();
        frame_start = 1'b1;
        @(negedge clk);
        frame_start = 1'b0;
        if (pe_v) begin
            for (int k = 0; k < NW; k++) begin ac_f[k] = pe_f[k]; ac_l[k] = pe_l[k]; end
            ac_cnt = pe_cnt; pe_v = 1'b0;
        end
        exp_skip = 0;
    endtask

    task automatic send_line(input int i);
        bit h;
        h = model_hit(i);
        line_start = 1'b1; line_idx = 12'(i);
        exp_q.push_back(h); idx_q.push_back(i);
        if (h) exp_skip++;
        @(negedge clk);
        line_start = 1'b0;
    endtask

    task automatic frame_close(input string req);
        frame_end = 1'b1;
        @(negedge clk);
        frame_end = 1'b0;
        chk(req, int'(skip_total), exp_skip);
    endtask

    task automatic full_frame(input string req);
        cur_req = req;
        frame_begin();
        for (int i = 0; i <= LAST; i++) send_line(i);
        frame_close(req);
    endtask

    // Monitor: compare every line decision against the scoreboard.
    always @(negedge clk) begin
        if (!rst) begin
            if (line_masked && !line_vld) begin
                vectors++; miscompares++;
                $display("FAIL R10 actual=masked_without_vld expected=no_mask");
            end
            if (line_vld) begin
                if (exp_q.size() == 0) begin
                    vectors++; miscompares++;
                    $display("FAIL R10 actual=extra_vld expected=none");
                end else begin
                    bit e;
                    int li;
                    e = exp_q.pop_front();
                    li = idx_q.pop_front();
                    vectors++;
                    if (line_masked !== e) begin
                        miscompares++;
                        $display("FAIL %s line %0d actual=%0d expected=%0d", cur_req, li, line_masked, e);
                    end
                end
            end
        end
    end

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    endtask

    initial begin
        #(5ns * 190000);
        miscompares++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        for (int k = 0; k < NW; k++) begin st_f[k] = 0; st_l[k] = 0; end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11 reset state
        chk("R11", int'(line_vld), 0);
        chk("R11", int'(line_masked), 0);
        chk("R11", int'(skip_total), 0);
        chk("R11", int'(cfg_err), 0);

        // R6: nothing live, nothing masked
        full_frame("R6");

        // Legal windows, one ending on the unaligned last line (R2)
        write_win(0, 0, 304, 1'b1, "R2");
        write_win(1, 1376, 2124, 1'b1, "R2");
        write_win(2, 3196, 3499, 1'b1, "R2");

        // R5: count written mid-frame must not affect this frame
        cur_req = "R5";
        frame_begin();
        for (int i = 0; i < 400; i++) send_line(i);
        write_cnt(3, 1'b1, "R5");
        for (int i = 400; i <= LAST; i++) send_line(i);
        frame_close("R5");

        // R7: table live from this frame: 305 + 749 + 304 lines
        full_frame("R7");
        chk("R7", exp_skip, 1358);

        // Illegal writes
        write_win(0, 5, 304, 1'b0, "R2");
        write_win(0, 0, 302, 1'b0, "R2");
        write_win(1, 3500, 3504, 1'b0, "R3");
        write_win(1, 1376, 3500, 1'b0, "R3");
        write_win(2, 8, 8, 1'b0, "R3");
        write_win(2, 16, 12, 1'b0, "R3");
        write_win(5, 0, 4, 1'b0, "R3");
        write_cnt(6, 1'b0, "R1");
        write_cnt(7, 1'b0, "R1");
        // R4: recommit staged list; it must be unchanged
        write_cnt(3, 1'b1, "R4");
        full_frame("R4");
        chk("R4", exp_skip, 1358);

        // R8: overlapping windows, lines 100..300 once each
        write_win(0, 100, 200, 1'b1, "R8");
        write_win(1, 148, 300, 1'b1, "R8");
        write_cnt(2, 1'b1, "R8");
        full_frame("R8");
        chk("R8", exp_skip, 201);

        // R1: all five slots, narrowest spans
        write_win(0, 0, 4, 1'b1, "R1");
        write_win(1, 8, 12, 1'b1, "R1");
        write_win(2, 3496, 3499, 1'b1, "R1");
        write_win(3, 2000, 2004, 1'b1, "R1");
        write_win(4, 1000, 1100, 1'b1, "R1");
        write_cnt(5, 1'b1, "R1");
        full_frame("R1");
        chk("R1", exp_skip, 120);

        // R9: total holds between frame ends
        repeat (4) @(negedge clk);
        chk("R9", int'(skip_total), 120);

        // R6: count back to zero
        write_cnt(0, 1'b1, "R6");
        full_frame("R6");

        repeat (3) @(negedge clk);
        chk("R10", exp_q.size(), 0);
        finish_run();
    end

endmodule